// File: doc/BRIEF.md
# Masked Packed FP64 Vector Adder

This block adds two vectors of IEEE 754 double-precision numbers lane by lane. A vector is 128, 256 or 512 bits wide, which gives 2, 4 or 8 lanes of 64 bits. Lane j occupies bits [64j+63:64j]. Every lane has its own combinational FP64 adder. A single output register captures the new destination vector in the clock edge where `go` is high.

Around each add the block applies the per-operation controls. A per-lane write mask can leave an unselected lane at its old value (merge) or clear it (zero). The low 64 bits of the second source can be broadcast to every lane. An embedded rounding mode can override the global one. Bits above the active width are either cleared or, in legacy mode, preserved. In legacy mode the current destination also serves as the first source.

Each operation also reports five exception flags. These are ORed into a sticky register that only reset clears.

Top module: `vfa_masked_add`

## Requirements
- R1: `width_sel` picks the lane count: 00 selects 2 lanes (128 bits), 01 selects 4 lanes (256 bits), and 10 or 11 select 8 lanes (512 bits). Lane j is bits [64j+63:64j] of every vector port.
- R2: When `go` is high at a clock edge, each active written lane of `dst_out` holds `src1` lane + `src2` lane, rounded in the selected mode, from that edge onward. `done` is high for exactly the cycle after that edge. When `go` is low, `dst_out` and `flags` hold their values.
- R3: When `mask_en` is 1 and `mask[j]` is 0, active lane j is not written. In merge mode (`zero_mode`=0) it takes `dst_in` lane j. In zero mode (`zero_mode`=1) it becomes all zeros.
- R4: When `bcast` and `src2_mem` are both 1 outside legacy mode, every lane adds `src2[63:0]` instead of its own `src2` lane.
- R5: The rounding mode is taken from `rc_embed` only when the width is 512, `bcast`=1, `src2_mem`=0 and `legacy`=0. Otherwise it is taken from `rc_global`. The encoding is 00 nearest-even, 01 toward -inf, 10 toward +inf, 11 toward zero. An operation that uses `rc_embed` leaves `flags` unchanged.
- R6: Outside legacy mode, `dst_out` bits above the active width are zero. In legacy mode (`legacy`=1):
  - the width is 128 bits;
  - the first source is `dst_in`;
  - bits [511:128] are copied from `dst_in`;
  - `mask_en`, `bcast` and `rc_embed` are ignored.
- R7: The flag bits are [0] invalid, [1] denormal operand, [2] overflow, [3] underflow (tiny and inexact), [4] inexact. They are sticky. Only active lanes that are written contribute to them.
- R8: A NaN operand gives that NaN with its quiet bit (bit 51) set; the first source wins if both are NaN. A signaling NaN operand raises invalid. Infinities of opposite sign give 0xFFF8000000000000 and raise invalid.
- R9: An exact zero sum of operands of opposite sign is +0, except under toward -inf, where it is -0. Two zeros of equal sign keep that sign.
- R10: On overflow the result is infinity under nearest-even, toward zero gives the largest finite value, and the directed modes give infinity only in their own direction. Overflow and inexact are raised.
- R11: After reset, `dst_out` is zero, `flags` is zero and `done` is 0.
- R12: Subnormal operands are added exactly into subnormal results and raise the denormal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Perform one operation at this edge |
| width_sel | input | 2 | Vector width select |
| legacy | input | 1 | Legacy 128-bit mode, destination is first source |
| mask_en | input | 1 | Enable per-lane write mask |
| mask | input | 8 | Per-lane write mask |
| zero_mode | input | 1 | 1 = clear unwritten lanes, 0 = merge |
| bcast | input | 1 | Broadcast / embedded-rounding control bit |
| src2_mem | input | 1 | Second operand comes from memory |
| rc_embed | input | 2 | Embedded rounding mode |
| rc_global | input | 2 | Global rounding mode |
| src1 | input | 512 | First source vector |
| src2 | input | 512 | Second source vector |
| dst_in | input | 512 | Current destination vector |
| dst_out | output | 512 | New destination vector |
| flags | output | 5 | Sticky exception flags |
| done | output | 1 | Operation result valid |

## Verification
Masking and exception reporting meet in the same cycle. A lane that is masked off or beyond the width can carry operands that would raise invalid, while other lanes compute ordinary sums. A directed case gives a masked lane infinity plus negative infinity and checks that `flags` stays clean and that the lane is zeroed or merged. Embedded rounding and broadcast share the `bcast` control bit and are told apart only by `src2_mem`. Random operations mix the two. The embedded mode is checked both by a directed rounding-up result and by flags that stay clear on an inexact sum.

// File: rtl/vfa_pkg.sv
package vfa_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_t;

    typedef struct packed {
        logic inexact;
        logic underflow;
        logic overflow;
        logic denormal;
        logic invalid;
    } fpflags_t;

    localparam int LANE_W = 64;
    localparam logic [63:0] QNAN_DEFAULT = 64'hFFF8_0000_0000_0000;

    // number of leading zeros in a 56-bit word
    function automatic logic [5:0] lzc56(input logic [55:0] v);
        logic [5:0] n;
        logic       hit;
        n   = '0;
        hit = 1'b0;
        for (int i = 55; i >= 0; i--) begin
            if (!hit) begin
                if (v[i]) hit = 1'b1;
                else      n   = n + 6'd1;
            end
        end
        return n;
    endfunction

    function automatic logic [3:0] lanes_for(input logic [1:0] ws);
        case (ws)
            2'b00:   return 4'd2;
            2'b01:   return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/vfa_lane_add.sv
module vfa_lane_add
    import vfa_pkg::*;
(
    input  logic [63:0] a,
    input  logic [63:0] b,
    input  rmode_t      rm,
    output logic [63:0] y,
    output fpflags_t    fl
);
    logic        sa, sb;
    logic [10:0] ea, eb;
    logic [51:0] fa, fb;
    assign {sa, ea, fa} = a;
    assign {sb, eb, fb} = b;

    logic a_nan, b_nan, a_inf, b_inf, a_sub, b_sub;
    assign a_nan = (ea == 11'h7FF) && (fa != '0);
    assign b_nan = (eb == 11'h7FF) && (fb != '0);
    assign a_inf = (ea == 11'h7FF) && (fa == '0);
    assign b_inf = (eb == 11'h7FF) && (fb == '0);
    assign a_sub = (ea == '0) && (fa != '0);
    assign b_sub = (eb == '0) && (fb != '0);

    logic        swap, sx, sy, lost, inc, inexact, tiny, to_inf;
    logic [10:0] ex, ey, diff, shamt;
    logic [52:0] mx, my;
    logic [56:0] al, sum;
    logic [55:0] m;
    logic [53:0] r;
    logic [12:0] e;

    always_comb begin
        y   = '0;
        fl  = '0;
        fl.denormal = a_sub | b_sub;
        swap = {eb, fb} > {ea, fa};
        sx = swap ? sb : sa;
        sy = swap ? sa : sb;
        ex = swap ? eb : ea;
        ey = swap ? ea : eb;
        mx = swap ? {(eb != '0), fb} : {(ea != '0), fa};
        my = swap ? {(ea != '0), fa} : {(eb != '0), fb};
        if (ex == '0) ex = 11'd1;
        if (ey == '0) ey = 11'd1;
        diff = ex - ey;
        al   = {1'b0, my, 3'b000};
        if (diff >= 11'd57) begin
            lost = |my;
            al   = '0;
        end else begin
            lost = |(al & ~({57{1'b1}} << diff));
            al   = al >> diff;
        end
        al[0] = al[0] | lost;
        sum = (sx == sy) ? ({1'b0, mx, 3'b000} + al) : ({1'b0, mx, 3'b000} - al);
        m = '0; e = '0; r = '0; shamt = '0;
        inc = 1'b0; inexact = 1'b0; tiny = 1'b0; to_inf = 1'b0;

        if (a_nan || b_nan) begin
            y = a_nan ? (a | 64'h0008_0000_0000_0000) : (b | 64'h0008_0000_0000_0000);
            fl.invalid = (a_nan && !fa[51]) || (b_nan && !fb[51]);
        end else if (a_inf && b_inf && (sa != sb)) begin
            y = QNAN_DEFAULT;
            fl.invalid = 1'b1;
        end else if (a_inf) begin
            y = a;
        end else if (b_inf) begin
            y = b;
        end else if (sum == '0) begin
            y = {((sx == sy) ? sx : (rm == RM_DOWN)), 63'd0};
        end else begin
            if (sum[56]) begin
                m    = sum[56:1];
                m[0] = m[0] | sum[0];
                e    = 13'(ex) + 13'd1;
            end else begin
                shamt = (11'(lzc56(sum[55:0])) < (ex - 11'd1)) ? 11'(lzc56(sum[55:0])) : (ex - 11'd1);
                m     = sum[55:0] << shamt;
                e     = 13'(ex) - 13'(shamt);
            end
            tiny    = !m[55];
            inexact = m[2] | m[1] | m[0];
            case (rm)
                RM_NEAR: inc = m[2] & (m[1] | m[0] | m[3]);
                RM_UP:   inc = !sx & inexact;
                RM_DOWN: inc = sx & inexact;
                default: inc = 1'b0;
            endcase
            r = {1'b0, m[55:3]} + 54'(inc);
            if (r[53]) begin
                r = r >> 1;
                e = e + 13'd1;
            end
            if (e >= 13'd2047) begin
                to_inf = (rm == RM_NEAR) || ((rm == RM_UP) && !sx) || ((rm == RM_DOWN) && sx);
                y = to_inf ? {sx, 11'h7FF, 52'd0} : {sx, 11'h7FE, {52{1'b1}}};
                fl.overflow = 1'b1;
                fl.inexact  = 1'b1;
            end else begin
                y = {sx, (r[52] ? e[10:0] : 11'd0), r[51:0]};
                fl.inexact   = inexact;
                fl.underflow = tiny & inexact;
            end
        end
    end
endmodule

// File: rtl/vfa_lane_pick.sv
module vfa_lane_pick (
    input  logic        active,
    input  logic        wr,
    input  logic        zero_mode,
    input  logic        keep_upper,
    input  logic [63:0] sum,
    input  logic [63:0] old,
    output logic [63:0] y
);
    always_comb begin
        if (!active)  y = keep_upper ? old : '0;
        else if (wr)  y = sum;
        else          y = zero_mode ? '0 : old;
    end
endmodule

// File: rtl/vfa_masked_add.sv
module vfa_masked_add
    import vfa_pkg::*;
#(
    parameter int MAX_LANES = 8,
    localparam int VEC_W = MAX_LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic [1:0]           width_sel,
    input  logic                 legacy,
    input  logic                 mask_en,
    input  logic [MAX_LANES-1:0] mask,
    input  logic                 zero_mode,
    input  logic                 bcast,
    input  logic                 src2_mem,
    input  logic [1:0]           rc_embed,
    input  logic [1:0]           rc_global,
    input  logic [VEC_W-1:0]     src1,
    input  logic [VEC_W-1:0]     src2,
    input  logic [VEC_W-1:0]     dst_in,
    output logic [VEC_W-1:0]     dst_out,
    output logic [4:0]           flags,
    output logic                 done
);
    logic [3:0] nlanes;
    logic       use_embed, do_bcast;
    rmode_t     rm;

    assign nlanes    = legacy ? 4'd2 : lanes_for(width_sel);
    assign use_embed = !legacy && (nlanes == 4'd8) && bcast && !src2_mem;
    assign do_bcast  = !legacy && bcast && src2_mem;
    assign rm        = rmode_t'(use_embed ? rc_embed : rc_global);

    logic [VEC_W-1:0]     next_vec;
    fpflags_t             lane_fl [MAX_LANES];
    logic [MAX_LANES-1:0] lane_live;

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
        logic [63:0] opa, opb, sum_j;
        logic        act, wr;
        assign opa = legacy ? dst_in[j*LANE_W +: LANE_W] : src1[j*LANE_W +: LANE_W];
        assign opb = do_bcast ? src2[LANE_W-1:0] : src2[j*LANE_W +: LANE_W];
        assign act = (j < int'(nlanes));
        assign wr  = legacy || !mask_en || mask[j];
        assign lane_live[j] = act && wr;

        vfa_lane_add u_add (
            .a  (opa),
            .b  (opb),
            .rm (rm),
            .y  (sum_j),
            .fl (lane_fl[j])
        );

        vfa_lane_pick u_pick (
            .active     (act),
            .wr         (wr),
            .zero_mode  (zero_mode),
            .keep_upper (legacy),
            .sum        (sum_j),
            .old        (dst_in[j*LANE_W +: LANE_W]),
            .y          (next_vec[j*LANE_W +: LANE_W])
        );
    end

    fpflags_t new_fl;
    always_comb begin
        new_fl = '0;
        for (int j = 0; j < MAX_LANES; j++) begin
            if (lane_live[j]) new_fl = new_fl | lane_fl[j];
        end
        if (use_embed) new_fl = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_out <= '0;
            flags   <= '0;
            done    <= 1'b0;
        end else begin
            done <= go;
            if (go) begin
                dst_out <= next_vec;
                flags   <= flags | new_fl;
            end
        end
    end
endmodule

// File: rtl/vfa_masked_add_chk.sv
module vfa_masked_add_chk #(
    parameter int MAX_LANES = 8,
    localparam int VEC_W = MAX_LANES * 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 go,
    input logic [1:0]           width_sel,
    input logic                 legacy,
    input logic                 mask_en,
    input logic [MAX_LANES-1:0] mask,
    input logic                 zero_mode,
    input logic                 bcast,
    input logic                 src2_mem,
    input logic [VEC_W-1:0]     dst_in,
    input logic [VEC_W-1:0]     dst_out,
    input logic [4:0]           flags,
    input logic                 done
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    AST_DONE_AFTER_GO: assert property (@(posedge clk) disable iff (rst || !past_ok)
        go |=> done); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !go |=> ($stable(dst_out) && $stable(flags) && !done)); // R2
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst || !past_ok)
        1'b1 |=> ((flags & $past(flags)) == $past(flags))); // R7
    AST_EMBED_QUIET: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (go && !legacy && width_sel[1] && bcast && !src2_mem) |=> $stable(flags)); // R5
    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (go && !legacy && width_sel == 2'b00) |=> (dst_out[VEC_W-1:128] == '0)); // R6
    AST_LEGACY_UPPER: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (go && legacy) |=> (dst_out[VEC_W-1:128] == $past(dst_in[VEC_W-1:128]))); // R6
    AST_ZERO_LANE0: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (go && !legacy && mask_en && zero_mode && !mask[0]) |=> (dst_out[63:0] == 64'd0)); // R3
endmodule

bind vfa_masked_add vfa_masked_add_chk #(.MAX_LANES(MAX_LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .width_sel (width_sel),
    .legacy    (legacy),
    .mask_en   (mask_en),
    .mask      (mask),
    .zero_mode (zero_mode),
    .bcast     (bcast),
    .src2_mem  (src2_mem),
    .dst_in    (dst_in),
    .dst_out   (dst_out),
    .flags     (flags),
    .done      (done)
);

// File: tb/vfa_masked_add_test.sv
module vfa_masked_add_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TINY = 64'h3C30_0000_0000_0000;
    localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] FMAX = 64'h7FEF_FFFF_FFFF_FFFF;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         go = 1'b0;
    logic [1:0]   width_sel = '0;
    logic         legacy = 1'b0, mask_en = 1'b0, zero_mode = 1'b0, bcast = 1'b0, src2_mem = 1'b0;
    logic [7:0]   mask = '0;
    logic [1:0]   rc_embed = '0, rc_global = '0;
    logic [511:0] src1 = '0, src2 = '0, dst_in = '0;
    logic [511:0] dst_out;
    logic [4:0]   flags;
    logic         done;
    int           total = 0;
    int           bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vfa_masked_add uut (
        .clk(clk), .rst(rst), .go(go), .width_sel(width_sel), .legacy(legacy),
        .mask_en(mask_en), .mask(mask), .zero_mode(zero_mode), .bcast(bcast),
        .src2_mem(src2_mem), .rc_embed(rc_embed), .rc_global(rc_global),
        .src1(src1), .src2(src2), .dst_in(dst_in), .dst_out(dst_out),
        .flags(flags), .done(done)
    );

    task automatic chk(input string req, input logic [511:0] got, input logic [511:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic fire();
        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
    endtask

    task automatic defaults();
        width_sel = 2'b00; legacy = 0; mask_en = 0; mask = '0; zero_mode = 0;
        bcast = 0; src2_mem = 0; rc_embed = 2'b00; rc_global = 2'b00;
        src1 = '0; src2 = '0; dst_in = '0;
    endtask

    function automatic logic [63:0] radd(input logic [63:0] a, input logic [63:0] b);
        return $realtobits($bitstoreal(a) + $bitstoreal(b));
    endfunction

    function automatic logic [63:0] rnd_num();
        return {1'($urandom), 11'(900 + $urandom_range(200)), 20'($urandom), 32'($urandom)};
    endfunction

    function automatic logic [511:0] model();
        logic [511:0] r;
        int n;
        r = '0;
        n = legacy ? 2 : (width_sel == 2'b00 ? 2 : (width_sel == 2'b01 ? 4 : 8));
        for (int j = 0; j < 8; j++) begin
            logic [63:0] old, a, b;
            old = dst_in[j*64 +: 64];
            if (j >= n) r[j*64 +: 64] = legacy ? old : 64'd0;
            else begin
                a = legacy ? old : src1[j*64 +: 64];
                b = (bcast && src2_mem && !legacy) ? src2[63:0] : src2[j*64 +: 64];
                if (legacy || !mask_en || mask[j]) r[j*64 +: 64] = radd(a, b);
                else r[j*64 +: 64] = zero_mode ? 64'd0 : old;
            end
        end
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R2 got=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        defaults();
        do_reset();
        // R11 reset state
        chk("R11 dst_out", dst_out, '0);
        chk("R11 flags", 512'(flags), '0);
        chk("R11 done", 512'(done), '0);

        // R2 R7 rounding up vs nearest, inexact bit4
        src1[63:0] = ONE; src2[63:0] = TINY; rc_global = 2'b10;
        fire();
        chk("R2 done", 512'(done), 512'd1);
        chk("R5 round up", dst_out, 512'(64'h3FF0_0000_0000_0001));
        chk("R7 inexact", 512'(flags), 512'(5'b10000));
        @(negedge clk);
        chk("R2 done one cycle", 512'(done), '0);
        rc_global = 2'b00;
        fire();
        chk("R5 nearest", dst_out, 512'(ONE));
        chk("R7 sticky", 512'(flags), 512'(5'b10000));

        // R5 embedded rounding at 512, flags untouched
        do_reset(); defaults();
        width_sel = 2'b10; bcast = 1; src2_mem = 0; rc_embed = 2'b10; rc_global = 2'b00;
        src1[63:0] = ONE; src2[63:0] = TINY;
        fire();
        chk("R5 embedded up", dst_out, 512'(64'h3FF0_0000_0000_0001));
        chk("R5 flags quiet", 512'(flags), '0);

        // R9 cancellation sign
        do_reset(); defaults();
        src1[63:0] = ONE; src2[63:0] = ONE | 64'h8000_0000_0000_0000; rc_global = 2'b01;
        src1[127:64] = 64'h8000_0000_0000_0000; src2[127:64] = 64'h8000_0000_0000_0000;
        fire();
        chk("R9 down gives -0", dst_out, {384'd0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000});
        rc_global = 2'b00;
        fire();
        chk("R9 nearest gives +0", dst_out, {384'd0, 64'h8000_0000_0000_0000, 64'd0});
        chk("R9 exact no flags", 512'(flags), '0);

        // R8 NaN cases
        do_reset(); defaults();
        src1[63:0] = PINF; src2[63:0] = NINF;
        src1[127:64] = 64'h7FF0_0000_0000_0001; src2[127:64] = ONE;
        fire();
        chk("R8 nan results", dst_out, {384'd0, 64'h7FF8_0000_0000_0001, 64'hFFF8_0000_0000_0000});
        chk("R8 invalid", 512'(flags), 512'(5'b00001));

        // R10 overflow
        do_reset(); defaults();
        src1[63:0] = FMAX; src2[63:0] = FMAX; rc_global = 2'b11;
        src1[127:64] = FMAX | 64'h8000_0000_0000_0000; src2[127:64] = FMAX | 64'h8000_0000_0000_0000;
        fire();
        chk("R10 toward zero", dst_out, {384'd0, FMAX | 64'h8000_0000_0000_0000, FMAX});
        chk("R10 flags", 512'(flags), 512'(5'b10100));
        rc_global = 2'b00;
        fire();
        chk("R10 nearest inf", dst_out, {384'd0, NINF, PINF});
        rc_global = 2'b10;
        fire();
        chk("R10 up", dst_out, {384'd0, FMAX | 64'h8000_0000_0000_0000, PINF});

        // R12 subnormals
        do_reset(); defaults();
        src1[63:0] = 64'd1; src2[63:0] = 64'd1;
        src1[127:64] = 64'h000F_FFFF_FFFF_FFFF; src2[127:64] = 64'd1;
        fire();
        chk("R12 subnormal sum", dst_out, {384'd0, 64'h0010_0000_0000_0000, 64'd2});
        chk("R12 denormal flag", 512'(flags), 512'(5'b00010));

        // R3 R7 masked lane with invalid operands, zero and merge
        do_reset(); defaults();
        width_sel = 2'b01; mask_en = 1; mask = 8'b0000_0001; zero_mode = 1;
        src1[63:0] = ONE; src2[63:0] = ONE;
        src1[127:64] = PINF; src2[127:64] = NINF;
        src1[191:128] = 64'h7FF0_0000_0000_0001;
        dst_in = {8{64'h1234_5678_9ABC_DEF0}};
        fire();
        chk("R3 zero masked", dst_out, {256'd0, 64'd0, 64'd0, 64'd0, 64'h4000_0000_0000_0000});
        chk("R7 masked lanes quiet", 512'(flags), '0);
        zero_mode = 0;
        fire();
        chk("R3 merge masked", dst_out, {256'd0, {3{64'h1234_5678_9ABC_DEF0}}, 64'h4000_0000_0000_0000});

        // R4 broadcast, R1 lane layout at 256
        do_reset(); defaults();
        width_sel = 2'b01; bcast = 1; src2_mem = 1;
        src1[255:0] = {64'h4010_0000_0000_0000, 64'h4008_0000_0000_0000, 64'h4000_0000_0000_0000, ONE};
        src2 = {{7{64'h4050_0000_0000_0000}}, ONE};
        fire();
        chk("R4 R1 broadcast", dst_out, {256'd0, 64'h4014_0000_0000_0000, 64'h4010_0000_0000_0000,
                                         64'h4008_0000_0000_0000, 64'h4000_0000_0000_0000});

        // R6 legacy mode
        do_reset(); defaults();
        legacy = 1; width_sel = 2'b10; mask_en = 1; mask = '0; zero_mode = 1;
        dst_in = {{6{64'hAAAA_5555_AAAA_5555}}, 64'h4000_0000_0000_0000, ONE};
        src1 = {8{FMAX}};
        src2[127:0] = {ONE, ONE};
        fire();
        chk("R6 legacy", dst_out, {{6{64'hAAAA_5555_AAAA_5555}}, 64'h4008_0000_0000_0000, 64'h4000_0000_0000_0000});

        // random mix, nearest rounding, R1 R2 R3 R4 R5 R6
        do_reset();
        for (int it = 0; it < 400; it++) begin
            logic [511:0] exp;
            defaults();
            width_sel = 2'($urandom_range(2));
            legacy    = ($urandom_range(4) == 0);
            mask_en   = 1'($urandom); mask = 8'($urandom);
            zero_mode = 1'($urandom); bcast = 1'($urandom); src2_mem = 1'($urandom);
            for (int j = 0; j < 8; j++) begin
                src1[j*64 +: 64]   = rnd_num();
                src2[j*64 +: 64]   = rnd_num();
                dst_in[j*64 +: 64] = rnd_num();
            end
            if (!legacy && width_sel == 2'b10 && bcast && !src2_mem) begin
                rc_embed = 2'b00; rc_global = 2'($urandom_range(3));
            end else begin
                rc_global = 2'b00; rc_embed = 2'($urandom_range(3));
            end
            exp = model();
            fire();
            chk("R2 random", dst_out, exp);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule